// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer

This block is a time base for a single clock domain. An enable-gated clock divider (by 1, 2 or 4) feeds a programmable prescaler, and each prescaler tick steps a main counter. The counter counts up, counts down, or counts center-aligned, turning at the reload value and at zero. Each wrap or turn is an update event.

An update event sets a sticky flag. The flag drives the interrupt output only while the interrupt enable is set. When the DMA enable is set, each update event also sends a one-cycle request pulse to an external DMA engine. Software sets up the block through a small write-only register port. Address 0 is control, address 1 is the prescaler value, address 2 is the reload value, and address 3 clears the flag.

The control word at address 0 has these fields. Bit 0 is run. Bits 2:1 are the mode: 00 up, 01 down, 10 center, and 11 behaves as up. Bits 4:3 are the clock division: 00 is /1, 01 is /2, and 10 or 11 is /4. Bit 5 is the interrupt enable. Bit 6 is the DMA enable.

Top module: `multimode_timer`

## Requirements
- R1: After reset, the counter value, update pulse, flag, interrupt and DMA request are all 0, and the timer is stopped.
- R2: The division field in control bits 4:3 divides the count rate: 00 by 1, 01 by 2, 10 and 11 by 4.
- R3: The prescaler divides its input by PSC+1. In up mode, update events are spaced div*(PSC+1)*(ARR+1) clock cycles apart.
- R4: Up mode (bits 2:1 = 00): the counter counts 0 up to ARR and then returns to 0. The update pulse is high in the cycle in which the counter shows 0 after the wrap.
- R5: Down mode (bits 2:1 = 01): the counter counts from ARR down to 0 and then reloads ARR. The update pulse coincides with the reloaded ARR value. Events are spaced div*(PSC+1)*(ARR+1) cycles apart, and the direction output is 1.
- R6: Center mode (bits 2:1 = 10): the counter runs 0 up to ARR, then back down to 0. It gives an update event at both turns, so events are spaced div*(PSC+1)*ARR cycles apart. The direction output is 1 while descending, including the cycle that shows ARR.
- R7: A PSC write while running takes effect only after the next update event. The period that is already under way completes at the old ratio. While stopped, the prescaler follows PSC directly.
- R8: An update event sets the flag. The flag stays set until a write to address 3 with bit 0 = 1 clears it.
- R9: The interrupt output is high only while the flag and the interrupt enable (control bit 5) are both set.
- R10: With the DMA enable (control bit 6) set, each update event gives a DMA request pulse in the same cycle as the update pulse. With the enable clear, no request is issued.
- R11: When run (control bit 0) is cleared, the counter and prescaler hold their values. Setting run again resumes counting from the held value.
- R12: With ARR = 0 in up mode, every count tick is an update event and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 PSC, 2 ARR, 3 flag clear) |
| wr_data | input | 16 | Register write data |
| cnt_value | output | 16 | Current counter value |
| cnt_down | output | 1 | 1 while the counter is descending |
| upd_evt | output | 1 | One-cycle update event pulse |
| flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request (flag gated by enable) |
| dma_req | output | 1 | One-cycle DMA request per update event |

## Verification
The checker tests several properties on every cycle:
- The flag is set by every update pulse and stays set unless cleared.
- A DMA pulse never appears without an update pulse.
- The interrupt is silent while its enable is clear.
- A stopped timer holds its counter.
- An up-mode update always shows 0, and a down-mode update shows the reload value.

Other behaviours can only be shown by the bench's scenarios:
- The exact spacing of update events for each mode, division and prescaler setting.
- The two turns of center-aligned counting.
- The deferred loading of a new prescaler value.
- Resuming from the held value.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   typedef enum logic [1:0] {
      MODE_UP     = 2'd0,
      MODE_DOWN   = 2'd1,
      MODE_CENTER = 2'd2,
      MODE_ALT_UP = 2'd3
   } cnt_mode_e;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_PSC   = 2'd1;
   localparam logic [1:0] ADDR_ARR   = 2'd2;
   localparam logic [1:0] ADDR_CLEAR = 2'd3;

   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_MODE_LO = 1;
   localparam int unsigned CTRL_DIV_LO  = 3;
   localparam int unsigned CTRL_IE_BIT  = 5;
   localparam int unsigned CTRL_DE_BIT  = 6;
   localparam int unsigned CTRL_USED_W  = 7;

   typedef struct packed {
      logic       de;
      logic       ie;
      logic [1:0] div;
      cnt_mode_e  mode;
      logic       run;
   } ctrl_t;

endpackage

// File: rtl/mmt_clkdiv.sv
module mmt_clkdiv (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_sel,
   output logic       tick
);
   logic [1:0] phase_q;
   logic [1:0] limit;

   always_comb begin
      case (div_sel)
         2'd0:    limit = 2'd0;
         2'd1:    limit = 2'd1;
         default: limit = 2'd3;
      endcase
   end

   assign tick = run && (phase_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (run) begin
         phase_q <= (phase_q >= limit) ? 2'd0 : phase_q + 2'd1;
      end
   end
endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
   parameter int unsigned PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             in_tick,
   input  logic             reload,
   input  logic [PSC_W-1:0] psc_in,
   output logic             out_tick
);
   logic [PSC_W-1:0] ratio_q;
   logic [PSC_W-1:0] phase_q;

   assign out_tick = in_tick && (phase_q >= ratio_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= '0;
      end else if (!run || reload) begin
         ratio_q <= psc_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (in_tick) begin
         phase_q <= out_tick ? '0 : phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
   import mmt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt,
   output logic             descending,
   output logic             wrap
);
   localparam int unsigned EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             dir_q, dir_nxt;
   logic             turn;
   logic [EXT_W-1:0] cnt_plus;

   assign cnt_plus = {1'b0, cnt_q} + EXT_W'(1);

   always_comb begin
      cnt_nxt = cnt_q;
      dir_nxt = 1'b0;
      turn    = 1'b0;
      case (mode)
         MODE_DOWN: begin
            if (cnt_q == '0) begin
               cnt_nxt = arr;
               turn    = 1'b1;
            end else begin
               cnt_nxt = cnt_q - 1'b1;
            end
         end
         MODE_CENTER: begin
            if (arr == '0) begin
               cnt_nxt = '0;
            end else if (!dir_q) begin
               if (cnt_plus >= {1'b0, arr}) begin
                  cnt_nxt = arr;
                  dir_nxt = 1'b1;
                  turn    = 1'b1;
               end else begin
                  cnt_nxt = cnt_plus[CNT_W-1:0];
               end
            end else begin
               if (cnt_q <= CNT_W'(1)) begin
                  cnt_nxt = '0;
                  dir_nxt = 1'b0;
                  turn    = 1'b1;
               end else begin
                  cnt_nxt = cnt_q - 1'b1;
                  dir_nxt = 1'b1;
               end
            end
         end
         default: begin
            if (cnt_q >= arr) begin
               cnt_nxt = '0;
               turn    = 1'b1;
            end else begin
               cnt_nxt = cnt_plus[CNT_W-1:0];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
         dir_q <= dir_nxt;
      end
   end

   assign cnt        = cnt_q;
   assign wrap       = tick && turn;
   assign descending = (mode == MODE_DOWN) || ((mode == MODE_CENTER) && dir_q);
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
   import mmt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt_value,
   output logic              cnt_down,
   output logic              upd_evt,
   output logic              flag,
   output logic              irq,
   output logic              dma_req
);
   localparam int unsigned MIN_DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("multimode_timer: CNT_W must lie in 2..32");
      end
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc_w
         $error("multimode_timer: PSC_W must lie in 1..32");
      end
      if (DATA_W < MIN_DATA_W || DATA_W < CTRL_USED_W) begin : g_bad_data_w
         $error("multimode_timer: DATA_W too narrow for registers");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] arr_q;
   logic             flag_q, upd_q, dma_q;
   logic             div_tick, cnt_tick, wrap;
   logic             clr_hit;

   assign clr_hit = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psc_q  <= '0;
         arr_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: begin
               ctrl_q.run  <= wr_data[CTRL_RUN_BIT];
               ctrl_q.mode <= cnt_mode_e'(wr_data[CTRL_MODE_LO +: 2]);
               ctrl_q.div  <= wr_data[CTRL_DIV_LO +: 2];
               ctrl_q.ie   <= wr_data[CTRL_IE_BIT];
               ctrl_q.de   <= wr_data[CTRL_DE_BIT];
            end
            ADDR_PSC: psc_q <= wr_data[PSC_W-1:0];
            ADDR_ARR: arr_q <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   mmt_clkdiv i_clkdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .div_sel (ctrl_q.div),
      .tick    (div_tick)
   );

   mmt_prescaler #(.PSC_W(PSC_W)) i_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.run),
      .in_tick  (div_tick),
      .reload   (wrap),
      .psc_in   (psc_q),
      .out_tick (cnt_tick)
   );

   mmt_counter #(.CNT_W(CNT_W)) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (cnt_tick),
      .mode       (ctrl_q.mode),
      .arr        (arr_q),
      .cnt        (cnt_value),
      .descending (cnt_down),
      .wrap       (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_q  <= 1'b0;
         dma_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         upd_q <= wrap;
         dma_q <= wrap && ctrl_q.de;
         if (wrap)         flag_q <= 1'b1;
         else if (clr_hit) flag_q <= 1'b0;
      end
   end

   assign upd_evt = upd_q;
   assign dma_req = dma_q;
   assign flag    = flag_q;
   assign irq     = flag_q && ctrl_q.ie;
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
   import mmt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [1:0]       mode,
   input logic             ie,
   input logic             clr_hit,
   input logic [CNT_W-1:0] arr,
   input logic [CNT_W-1:0] cnt_value,
   input logic             upd_evt,
   input logic             flag,
   input logic             irq,
   input logic             dma_req
);
   assert_dma_needs_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> upd_evt);

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |-> flag);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_hit) |=> flag);

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> !irq);

   assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   assert_frozen_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_value));

   assert_up_wraps_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_evt && $past(mode) == MODE_UP) |-> (cnt_value == '0));

   assert_down_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_evt && $past(mode) == MODE_DOWN) |-> (cnt_value == $past(arr)));
endmodule

bind multimode_timer mmt_checker #(.CNT_W(CNT_W)) i_mmt_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (ctrl_q.run),
   .mode      (ctrl_q.mode),
   .ie        (ctrl_q.ie),
   .clr_hit   (clr_hit),
   .arr       (arr_q),
   .cnt_value (cnt_value),
   .upd_evt   (upd_evt),
   .flag      (flag),
   .irq       (irq),
   .dma_req   (dma_req)
);

// File: tb/test_multimode_timer.sv
module test_multimode_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;
   // mode, div code, psc, arr, expected spacing in clock cycles
   localparam int VEC [NVEC][5] = '{
      '{0, 0, 0, 5, 6},
      '{0, 1, 2, 3, 24},
      '{0, 2, 1, 2, 24},
      '{1, 0, 0, 4, 5},
      '{1, 1, 1, 3, 16},
      '{2, 0, 0, 4, 4},
      '{2, 3, 0, 3, 12},
      '{2, 0, 2, 1, 3},
      '{0, 0, 0, 0, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cnt_value;
   logic        cnt_down, upd_evt, flag, irq, dma_req;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   multimode_timer i_multimode_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_value(cnt_value), .cnt_down(cnt_down), .upd_evt(upd_evt),
      .flag(flag), .irq(irq), .dma_req(dma_req)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] ctrl_word(int run, int mode, int div, int ie, int de);
      return 16'((run & 1) | ((mode & 3) << 1) | ((div & 3) << 3) | ((ie & 1) << 5) | ((de & 1) << 6));
   endfunction

   task automatic wait_upd(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!upd_evt && n < 5000);
      if (!upd_evt) chk("R3", "update never seen", 0, 1);
   endtask

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL all watchdog: actual=%0d expected=%0d", 0, 1);
         report();
      end
   end

   initial begin
      int n, m, v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "cnt_value", cnt_value, 0);
      chk("R1", "upd_evt", upd_evt, 0);
      chk("R1", "flag", flag, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "dma_req", dma_req, 0);
      repeat (5) @(negedge clk);
      chk("R1", "stopped cnt", cnt_value, 0);

      // table of mode / division / prescaler vectors (R2 R3 R4 R5 R6 R12)
      for (int i = 0; i < NVEC; i++) begin
         reg_write(2'd0, ctrl_word(0, VEC[i][0], VEC[i][1], 0, 0));
         reg_write(2'd1, 16'(VEC[i][2]));
         reg_write(2'd2, 16'(VEC[i][3]));
         reg_write(2'd0, ctrl_word(1, VEC[i][0], VEC[i][1], 0, 0));
         wait_upd(n);
         wait_upd(n);
         chk(VEC[i][1] != 0 ? "R2" : "R3", $sformatf("spacing vec%0d", i), n, VEC[i][4]);
         case (VEC[i][0])
            0: chk(VEC[i][3] == 0 ? "R12" : "R4", "cnt at update", cnt_value, 0);
            1: begin
               chk("R5", "cnt at update", cnt_value, VEC[i][3]);
               chk("R5", "cnt_down", cnt_down, 1);
            end
            default: begin
               for (int k = 0; k < 2; k++) begin
                  if (cnt_value == VEC[i][3]) chk("R6", "down at top", cnt_down, 1);
                  else begin
                     chk("R6", "cnt at bottom", cnt_value, 0);
                     chk("R6", "up at bottom", cnt_down, 0);
                  end
                  wait_upd(n);
                  chk("R6", "half spacing", n, VEC[i][4]);
               end
            end
         endcase
         chk("R8", "flag after update", flag, 1);
      end

      // R7: prescaler write while running waits for the next update
      reg_write(2'd0, ctrl_word(0, 0, 0, 0, 0));
      reg_write(2'd1, 16'd0);
      reg_write(2'd2, 16'd3);
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 0));
      wait_upd(n);
      wait_upd(n);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd1;
      @(negedge clk);
      wr_en = 1'b0;
      wait_upd(m);
      chk("R7", "period under way", n + 0 * m + m + 1 - n, 4);
      wait_upd(n);
      chk("R7", "period after update", n, 8);

      // R11: freeze and resume
      reg_write(2'd0, ctrl_word(0, 0, 0, 0, 0));
      reg_write(2'd1, 16'd0);
      reg_write(2'd2, 16'd200);
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 0));
      repeat (10) @(negedge clk);
      reg_write(2'd0, ctrl_word(0, 0, 0, 0, 0));
      v = cnt_value;
      repeat (6) @(negedge clk);
      chk("R11", "held while stopped", cnt_value, v);
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 0));
      chk("R11", "held until tick", cnt_value, v);
      @(negedge clk);
      chk("R11", "resumed from held", cnt_value, v + 1);

      // R8/R9: flag, clearing, interrupt gating
      reg_write(2'd0, ctrl_word(0, 0, 0, 0, 0));
      reg_write(2'd3, 16'd1);
      chk("R8", "flag cleared", flag, 0);
      reg_write(2'd2, 16'd2);
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 0));
      wait_upd(n);
      reg_write(2'd0, ctrl_word(0, 0, 0, 0, 0));
      chk("R8", "flag set", flag, 1);
      chk("R9", "irq with ie=0", irq, 0);
      repeat (4) @(negedge clk);
      chk("R8", "flag sticky", flag, 1);
      reg_write(2'd0, ctrl_word(0, 0, 0, 1, 0));
      chk("R9", "irq with ie=1", irq, 1);
      reg_write(2'd3, 16'd1);
      chk("R9", "irq after clear", irq, 0);
      chk("R8", "flag after clear", flag, 0);

      // R10: DMA request pulse
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 1));
      wait_upd(n);
      chk("R10", "dma with update", dma_req, 1);
      @(negedge clk);
      chk("R10", "dma one cycle", dma_req, 0);
      reg_write(2'd0, ctrl_word(1, 0, 0, 0, 0));
      v = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (dma_req) v++;
      end
      chk("R10", "no dma when disabled", v, 0);

      done = 1'b1;
      report();
   end
endmodule